// File: doc/BRIEF.md
# Multichannel Serial Link Double-Buffer Controller

This controller sits between a multichannel bit-oriented serial link engine and a host. Every channel owns two receive blocks and two transmit blocks inside a 128-byte shared buffer window. At any time the serial side fills or drains one block of each pair and the host works on the other. The controller decides when the two blocks of a pair change owner, produces the byte address for every received byte, and raises per-channel receive interrupts that carry the cause and the byte count of the block that was handed over.

The window is split according to a channel-count setting. One, two or four channels share the same 64-byte receive half and 64-byte transmit half, so the block size shrinks as the channel count grows. A receive pair changes owner when the serial side fills its block or when a frame ends. A transmit pair changes owner each time the host issues a start-transmission command. If the serial side needs a fresh block while the host has not yet released the previous one, the controller flags an overflow and protects the host's block. A separate periodic tick runs at one of two selectable rates.

Top module: `pp_buf_ctrl`

## Requirements
- R1: `mode_i` selects the channel count: 0 gives 1 channel with 32-byte blocks, 1 gives 2 channels with 16-byte blocks, and 2 or 3 give 4 channels with 8-byte blocks. Byte, end-of-frame, release and start commands aimed at a channel number at or above the count have no effect: `rx_wr_en_o` stays low and that channel's flags do not change.
- R2: With block size S, block b (0 or 1) of channel c starts at 0x40 + (2c+b)*S for receive and at (2c+b)*S for transmit. Field c of each `*_base_o` bus (bits 7c+6..7c) gives the base of the block the serial side owns (`*_ser_base_o`) or the host owns (`*_host_base_o`).
- R3: In the same cycle as `rx_wr_i`, `rx_wr_addr_o` is the receive base that the serial side owns plus the number of bytes already in that block, and `rx_wr_en_o` is high unless the byte is dropped.
- R4: A byte that fills the serial block while the host block is free swaps the pair. On the next edge the controller sets `rx_irq_o[c]`, sets the full flag, clears the end flag and reports count S.
- R5: An end-of-frame on a block that holds bytes, or on an empty block when no fill swap has happened since the previous end-of-frame, swaps the pair. The interrupt and the end flag are set, the full flag is cleared, and the count is the number of bytes in the block (0 is allowed).
- R6: An end-of-frame on an empty block after a fill swap in the same frame does not swap. It sets the interrupt and the end flag, clears the full flag and reports count 0.
- R7: If a swap is due while the host block is still held, no swap occurs and `rx_ovf_o[c]` is set. A fill keeps the block full and drops the bytes that follow (`rx_wr_en_o` low). An end-of-frame empties the serial block so that the next byte goes to its base.
- R8: `host_rel_i` for channel c hands the host block back, and clears `rx_irq_o[c]` and `rx_ovf_o[c]`.
- R9: `host_tx_start_i` for channel c exchanges that channel's transmit serial and host bases on the next edge.
- R10: `tick_o` is a one-cycle pulse every `TICK_SHORT` cycles when `tick_sel_i` is 0 and every `TICK_LONG` cycles when it is 1.
- R11: After reset, block 0 belongs to the serial side in both directions on every channel. All interrupt, overflow, status and count values are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Channel-count setting |
| tick_sel_i | input | 1 | Timer rate: 0 short period, 1 long period |
| rx_wr_i | input | 1 | Serial side delivers one received byte |
| rx_eof_i | input | 1 | Serial side signals end of frame |
| rx_ch_i | input | 2 | Channel of the receive event |
| rx_wr_addr_o | output | 7 | Buffer address for the delivered byte |
| rx_wr_en_o | output | 1 | Byte may be written (not dropped) |
| host_ch_i | input | 2 | Channel of the host command |
| host_rel_i | input | 1 | Host releases its receive block |
| host_tx_start_i | input | 1 | Host start-transmission command |
| rx_ser_base_o | output | 28 | Per-channel receive base owned by the serial side |
| rx_host_base_o | output | 28 | Per-channel receive base owned by the host |
| tx_ser_base_o | output | 28 | Per-channel transmit base owned by the serial side |
| tx_host_base_o | output | 28 | Per-channel transmit base owned by the host |
| rx_irq_o | output | 4 | Per-channel receive interrupt |
| rx_ovf_o | output | 4 | Per-channel receive overflow |
| rx_stat_full_o | output | 4 | Last interrupt came from a full block |
| rx_stat_eof_o | output | 4 | Last interrupt came from an end of frame |
| rx_stat_cnt_o | output | 24 | Per-channel byte count of the handed-over block, 6 bits each |
| tick_o | output | 1 | Periodic timer pulse |

## Verification
The byte address and the write enable are combinational, so the bench reads them 1 ns after it drives `rx_wr_i`, before the capturing edge. Swaps, interrupts, status, overflow and transmit exchanges take effect on the first rising edge after the command. The bench drives each command for exactly one cycle between falling edges and checks these results at the next falling edge. The base outputs follow `mode_i` without a register and are checked in the cycle the mode is applied. Tick spacing is measured by counting falling edges from one pulse to the next.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_FULL = 2'd1,
    CAUSE_EOF  = 2'd2
  } swap_cause_e;
endpackage

// File: rtl/pp_tick.sv
module pp_tick #(
  parameter int unsigned TICK_SHORT = 320,
  parameter int unsigned TICK_LONG  = 2000,
  localparam int unsigned CW = $clog2(TICK_LONG + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  output logic tick_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim    = sel_i ? CW'(TICK_LONG - 1) : CW'(TICK_SHORT - 1);
  assign tick_o = (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assert_tick_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/pp_rx_chan.sv
module pp_rx_chan
  import pp_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] blk_i,
  input  logic             wr_i,
  input  logic             eof_i,
  input  logic             rel_i,
  output logic             act_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wr_ok_o,
  output logic             irq_o,
  output logic             ovf_o,
  output logic             st_full_o,
  output logic             st_eof_o,
  output logic [CNT_W-1:0] st_cnt_o
);
  logic             act_q, busy_q, irq_q, ovf_q, full_seen_q;
  logic [CNT_W-1:0] cnt_q, st_cnt_q;
  swap_cause_e      cause_q;
  logic             busy_eff;

  assign busy_eff = busy_q & ~rel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q       <= 1'b0;
      busy_q      <= 1'b0;
      irq_q       <= 1'b0;
      ovf_q       <= 1'b0;
      full_seen_q <= 1'b0;
      cnt_q       <= '0;
      st_cnt_q    <= '0;
      cause_q     <= CAUSE_NONE;
    end else begin
      if (rel_i) begin
        busy_q <= 1'b0;
        irq_q  <= 1'b0;
        ovf_q  <= 1'b0;
      end
      if (wr_i) begin
        if (cnt_q == blk_i) begin
          ovf_q <= 1'b1;                      // block held full: byte dropped
        end else if (cnt_q == blk_i - 1'b1) begin
          if (busy_eff) begin
            cnt_q <= blk_i;
            ovf_q <= 1'b1;
          end else begin
            act_q       <= ~act_q;
            cnt_q       <= '0;
            busy_q      <= 1'b1;
            irq_q       <= 1'b1;
            cause_q     <= CAUSE_FULL;
            st_cnt_q    <= blk_i;
            full_seen_q <= 1'b1;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (eof_i) begin
        full_seen_q <= 1'b0;
        if (cnt_q == '0 && full_seen_q) begin
          irq_q    <= 1'b1;                   // frame ended on a block edge
          cause_q  <= CAUSE_EOF;
          st_cnt_q <= '0;
        end else if (busy_eff) begin
          ovf_q <= 1'b1;
          cnt_q <= '0;
        end else begin
          act_q    <= ~act_q;
          cnt_q    <= '0;
          busy_q   <= 1'b1;
          irq_q    <= 1'b1;
          cause_q  <= CAUSE_EOF;
          st_cnt_q <= cnt_q;
        end
      end
    end
  end

  assign act_o     = act_q;
  assign cnt_o     = cnt_q;
  assign wr_ok_o   = (cnt_q != blk_i);
  assign irq_o     = irq_q;
  assign ovf_o     = ovf_q;
  assign st_full_o = (cause_q == CAUSE_FULL);
  assign st_eof_o  = (cause_q == CAUSE_EOF);
  assign st_cnt_o  = st_cnt_q;

  assert_swap_needs_free_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q != $past(act_q)) |-> (!$past(busy_q) || $past(rel_i)));

  assert_irq_on_swap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q != $past(act_q)) |-> (irq_q && busy_q));

  assert_drop_sets_ovf_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && cnt_q == blk_i) |=> (ovf_q && $stable(act_q)));
endmodule

// File: rtl/pp_buf_ctrl.sv
module pp_buf_ctrl #(
  parameter int unsigned NCH        = 4,
  parameter int unsigned BLK_MAX    = 32,
  parameter int unsigned TICK_SHORT = 320,
  parameter int unsigned TICK_LONG  = 2000,
  localparam int unsigned LG_NCH = $clog2(NCH),
  localparam int unsigned MODE_W = $clog2(LG_NCH + 1),
  localparam int unsigned CH_W   = $clog2(NCH),
  localparam int unsigned ADDR_W = $clog2(4 * BLK_MAX),
  localparam int unsigned CNT_W  = $clog2(BLK_MAX + 1),
  localparam int unsigned RX_OFF = 2 * BLK_MAX
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [MODE_W-1:0]       mode_i,
  input  logic                    tick_sel_i,
  input  logic                    rx_wr_i,
  input  logic                    rx_eof_i,
  input  logic [CH_W-1:0]         rx_ch_i,
  output logic [ADDR_W-1:0]       rx_wr_addr_o,
  output logic                    rx_wr_en_o,
  input  logic [CH_W-1:0]         host_ch_i,
  input  logic                    host_rel_i,
  input  logic                    host_tx_start_i,
  output logic [NCH*ADDR_W-1:0]   rx_ser_base_o,
  output logic [NCH*ADDR_W-1:0]   rx_host_base_o,
  output logic [NCH*ADDR_W-1:0]   tx_ser_base_o,
  output logic [NCH*ADDR_W-1:0]   tx_host_base_o,
  output logic [NCH-1:0]          rx_irq_o,
  output logic [NCH-1:0]          rx_ovf_o,
  output logic [NCH-1:0]          rx_stat_full_o,
  output logic [NCH-1:0]          rx_stat_eof_o,
  output logic [NCH*CNT_W-1:0]    rx_stat_cnt_o,
  output logic                    tick_o
);
  logic [MODE_W-1:0] lg;
  logic [CNT_W-1:0]  blk;
  logic [NCH-1:0]    ch_en, rx_act, rx_ok, tx_act_q;
  logic [CNT_W-1:0]  rx_cnt [NCH];

  assign lg  = (mode_i > MODE_W'(LG_NCH)) ? MODE_W'(LG_NCH) : mode_i;
  assign blk = CNT_W'(BLK_MAX >> lg);

  function automatic logic [ADDR_W-1:0] blk_addr(input logic rx, input int unsigned c,
                                                 input logic b, input logic [MODE_W-1:0] l);
    int unsigned idx;
    idx = 2 * c + (b ? 1 : 0);
    return ADDR_W'((rx ? RX_OFF : 0) + ((idx * BLK_MAX) >> l));
  endfunction

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic wr_c, eof_c, rel_c, start_c;

    assign ch_en[c] = (c < (1 << lg));
    assign wr_c     = rx_wr_i  && rx_ch_i == CH_W'(c) && ch_en[c];
    assign eof_c    = rx_eof_i && rx_ch_i == CH_W'(c) && ch_en[c];
    assign rel_c    = host_rel_i      && host_ch_i == CH_W'(c) && ch_en[c];
    assign start_c  = host_tx_start_i && host_ch_i == CH_W'(c) && ch_en[c];

    pp_rx_chan #(.CNT_W(CNT_W)) i_rx (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .blk_i     (blk),
      .wr_i      (wr_c),
      .eof_i     (eof_c),
      .rel_i     (rel_c),
      .act_o     (rx_act[c]),
      .cnt_o     (rx_cnt[c]),
      .wr_ok_o   (rx_ok[c]),
      .irq_o     (rx_irq_o[c]),
      .ovf_o     (rx_ovf_o[c]),
      .st_full_o (rx_stat_full_o[c]),
      .st_eof_o  (rx_stat_eof_o[c]),
      .st_cnt_o  (rx_stat_cnt_o[c*CNT_W +: CNT_W])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      tx_act_q[c] <= 1'b0;
      else if (start_c) tx_act_q[c] <= ~tx_act_q[c];
    end

    assign rx_ser_base_o [c*ADDR_W +: ADDR_W] = blk_addr(1'b1, c,  rx_act[c],   lg);
    assign rx_host_base_o[c*ADDR_W +: ADDR_W] = blk_addr(1'b1, c, ~rx_act[c],   lg);
    assign tx_ser_base_o [c*ADDR_W +: ADDR_W] = blk_addr(1'b0, c,  tx_act_q[c], lg);
    assign tx_host_base_o[c*ADDR_W +: ADDR_W] = blk_addr(1'b0, c, ~tx_act_q[c], lg);

    assert_tx_swap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_c |=> (tx_act_q[c] != $past(tx_act_q[c])));
  end

  always_comb begin
    rx_wr_addr_o = '0;
    rx_wr_en_o   = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      if (rx_ch_i == CH_W'(c)) begin
        rx_wr_addr_o = rx_ser_base_o[c*ADDR_W +: ADDR_W] + ADDR_W'(rx_cnt[c]);
        rx_wr_en_o   = rx_wr_i && ch_en[c] && rx_ok[c];
      end
    end
  end

  pp_tick #(.TICK_SHORT(TICK_SHORT), .TICK_LONG(TICK_LONG)) i_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (tick_sel_i),
    .tick_o (tick_o)
  );
endmodule

// File: tb/test_pp_buf_ctrl.sv
`timescale 1ns/1ps
module test_pp_buf_ctrl;
  localparam int TS = 5;
  localparam int TL = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'd2;
  logic        tick_sel = 1'b0;
  logic        rx_wr = 1'b0, rx_eof = 1'b0;
  logic [1:0]  rx_ch = '0, host_ch = '0;
  logic        host_rel = 1'b0, host_start = 1'b0;
  logic [6:0]  wr_addr;
  logic        wr_en;
  logic [27:0] rxs, rxh, txs, txh;
  logic [3:0]  irq, ovf, st_full, st_eof;
  logic [23:0] st_cnt;
  logic        tick;

  int tests = 0, fails = 0;
  logic [6:0] cap_addr;
  logic       cap_en;

  always #2 clk = ~clk;

  pp_buf_ctrl #(.TICK_SHORT(TS), .TICK_LONG(TL)) i_pp_buf_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .tick_sel_i(tick_sel),
    .rx_wr_i(rx_wr), .rx_eof_i(rx_eof), .rx_ch_i(rx_ch),
    .rx_wr_addr_o(wr_addr), .rx_wr_en_o(wr_en),
    .host_ch_i(host_ch), .host_rel_i(host_rel), .host_tx_start_i(host_start),
    .rx_ser_base_o(rxs), .rx_host_base_o(rxh), .tx_ser_base_o(txs), .tx_host_base_o(txh),
    .rx_irq_o(irq), .rx_ovf_o(ovf), .rx_stat_full_o(st_full), .rx_stat_eof_o(st_eof),
    .rx_stat_cnt_o(st_cnt), .tick_o(tick)
  );

  typedef struct packed {
    logic [1:0] mode;
    logic [1:0] ch;
    logic [6:0] rxs, rxh, txs, txh;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'd0, 2'd0, 7'h40, 7'h60, 7'h00, 7'h20},
    '{2'd1, 2'd0, 7'h40, 7'h50, 7'h00, 7'h10},
    '{2'd1, 2'd1, 7'h60, 7'h70, 7'h20, 7'h30},
    '{2'd2, 2'd0, 7'h40, 7'h48, 7'h00, 7'h08},
    '{2'd2, 2'd3, 7'h70, 7'h78, 7'h30, 7'h38},
    '{2'd3, 2'd2, 7'h60, 7'h68, 7'h20, 7'h28}
  };

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic put_byte(input logic [1:0] ch);
    @(negedge clk); rx_ch = ch; rx_wr = 1'b1;
    #1; cap_addr = wr_addr; cap_en = wr_en;
    @(negedge clk); rx_wr = 1'b0;
  endtask

  task automatic put_eof(input logic [1:0] ch);
    @(negedge clk); rx_ch = ch; rx_eof = 1'b1;
    @(negedge clk); rx_eof = 1'b0;
  endtask

  task automatic release_ch(input logic [1:0] ch);
    @(negedge clk); host_ch = ch; host_rel = 1'b1;
    @(negedge clk); host_rel = 1'b0;
  endtask

  task automatic tx_start(input logic [1:0] ch);
    @(negedge clk); host_ch = ch; host_start = 1'b1;
    @(negedge clk); host_start = 1'b0;
  endtask

  function automatic int cnt_of(input int ch);
    return int'(st_cnt[ch*6 +: 6]);
  endfunction

  function automatic int rxs_of(input int ch);
    return int'(rxs[ch*7 +: 7]);
  endfunction

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11 irq", int'(irq), 0);
    chk("R11 ovf", int'(ovf), 0);
    chk("R11 stat cnt", int'(st_cnt), 0);
    chk("R11 stat flags", int'({st_full, st_eof}), 0);

    // R1/R2 base table, block 0 serial-owned after reset
    foreach (VECS[i]) begin
      mode = VECS[i].mode;
      #1;
      chk("R2 rx ser",  int'(rxs[VECS[i].ch*7 +: 7]), int'(VECS[i].rxs));
      chk("R2 rx host", int'(rxh[VECS[i].ch*7 +: 7]), int'(VECS[i].rxh));
      chk("R2 tx ser",  int'(txs[VECS[i].ch*7 +: 7]), int'(VECS[i].txs));
      chk("R2 tx host", int'(txh[VECS[i].ch*7 +: 7]), int'(VECS[i].txh));
    end
    mode = 2'd2;  // 4 channels, 8-byte blocks

    // R3/R4 fill channel 0
    for (int k = 0; k < 7; k++) begin
      put_byte(2'd0);
      chk("R3 addr", int'(cap_addr), 'h40 + k);
      chk("R3 en", int'(cap_en), 1);
    end
    chk("R4 no early irq", int'(irq[0]), 0);
    put_byte(2'd0);
    chk("R3 last addr", int'(cap_addr), 'h47);
    chk("R4 irq", int'(irq[0]), 1);
    chk("R4 full", int'({st_full[0], st_eof[0]}), 2);
    chk("R4 cnt", cnt_of(0), 8);
    chk("R4 ser base", rxs_of(0), 'h48);
    chk("R4 host base", int'(rxh[6:0]), 'h40);

    // R6 end of frame on block edge
    put_eof(2'd0);
    chk("R6 no swap", rxs_of(0), 'h48);
    chk("R6 eof flag", int'({st_full[0], st_eof[0]}), 1);
    chk("R6 cnt", cnt_of(0), 0);
    chk("R6 irq", int'(irq[0]), 1);

    // R8 release
    release_ch(2'd0);
    chk("R8 irq clear", int'(irq[0]), 0);

    // R5 end of frame with data
    for (int k = 0; k < 3; k++) begin
      put_byte(2'd0);
      chk("R3 addr blk1", int'(cap_addr), 'h48 + k);
    end
    put_eof(2'd0);
    chk("R5 swap", rxs_of(0), 'h40);
    chk("R5 eof flag", int'({st_full[0], st_eof[0]}), 1);
    chk("R5 cnt", cnt_of(0), 3);
    chk("R5 irq", int'(irq[0]), 1);

    // R7 overflow while host holds block
    for (int k = 0; k < 8; k++) put_byte(2'd0);
    chk("R7 ovf on fill", int'(ovf[0]), 1);
    chk("R7 no swap", rxs_of(0), 'h40);
    put_byte(2'd0);
    chk("R7 drop en", int'(cap_en), 0);
    put_eof(2'd0);
    chk("R7 eof no swap", rxs_of(0), 'h40);
    chk("R7 ovf kept", int'(ovf[0]), 1);
    release_ch(2'd0);
    chk("R8 ovf clear", int'(ovf[0]), 0);
    chk("R8 irq clear 2", int'(irq[0]), 0);
    put_byte(2'd0);
    chk("R7 count cleared", int'(cap_addr), 'h40);
    put_eof(2'd0);
    chk("R5 swap 1 byte", rxs_of(0), 'h48);
    chk("R5 cnt 1", cnt_of(0), 1);
    release_ch(2'd0);

    // R5 empty frame without prior fill
    put_eof(2'd0);
    chk("R5 empty swap", rxs_of(0), 'h40);
    chk("R5 empty cnt", cnt_of(0), 0);
    chk("R5 empty irq", int'(irq[0]), 1);
    release_ch(2'd0);

    // R3 other channel
    put_byte(2'd1);
    chk("R3 ch1 addr", int'(cap_addr), 'h50);
    chk("R3 ch1 isolation", int'(irq[0]), 0);

    // R9 transmit swap
    tx_start(2'd2);
    chk("R9 tx ser", int'(txs[2*7 +: 7]), 'h28);
    chk("R9 tx host", int'(txh[2*7 +: 7]), 'h20);
    tx_start(2'd2);
    chk("R9 tx back", int'(txs[2*7 +: 7]), 'h20);

    // R1 inactive channel in 1-channel mode
    mode = 2'd0;
    put_byte(2'd1);
    chk("R1 inactive en", int'(cap_en), 0);
    put_eof(2'd1);
    chk("R1 inactive irq", int'(irq[1]), 0);
    chk("R1 1ch base", rxs_of(0), 'h40);

    // R10 timer spacing
    begin
      int n;
      tick_sel = 1'b0;
      do @(negedge clk); while (!tick);
      n = 0;
      do begin @(negedge clk); n++; end while (!tick);
      chk("R10 short period", n, TS);
      @(negedge clk);
      chk("R10 single pulse", int'(tick), 0);
      tick_sel = 1'b1;
      do @(negedge clk); while (!tick);
      n = 0;
      do begin @(negedge clk); n++; end while (!tick);
      chk("R10 long period", n, TL);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule